// File: doc/BRIEF.md
# Register Access Protection Filter

This block sits between a serial register interface and a register file with 128 entries and 7-bit addresses. Every read and write request passes through it. The block decides whether the access is allowed and forwards only the allowed ones. A write that is not allowed never reaches the register file. A read that is not allowed returns zero in place of the register contents. The block also produces a one-cycle violation pulse for each rejected write.

The permissions come from a single seal flag. The flag mirrors bit 6 of the configuration register at address 0x05, and the filter holds it itself. A small state machine tracks the flag and has two named states:
- `ST_OPEN`: unsealed.
- `ST_SEALED`: sealed.

There are two transitions:
- OPEN to SEALED is taken on an allowed write to 0x05 whose bit 6 is 1.
- SEALED to SEALED holds the state until reset. No write can leave it, because 0x05 becomes write-protected once sealed.

During reset the state loads from a fuse input: 1 selects `ST_SEALED`, 0 selects `ST_OPEN`.

Top module: `acc_protect_filter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the seal loads from `fuse_seal`. `sealed_o` shows that value after reset, and `viol_o` is 0.
- R2: Unsealed, addresses 0x00–0x0F and 0x78–0x7F are readable and writable. A write raises `rf_we` in the same cycle. A read returns `rf_rdata` on `rsp_rdata`.
- R3: Unsealed, addresses 0x10–0x1F and 0x77 return `rf_rdata` on a read, but a write to them keeps `rf_we` low.
- R4: Unsealed, every other address (0x20–0x76) returns 0x00 on a read and keeps `rf_we` low on a write.
- R5: Sealed, `rf_we` rises only for writes to 0x7B and 0x7C. A write to any other address is dropped.
- R6: Sealed, reads of 0x77–0x7F return `rf_rdata`, and reads of every other address return 0x00.
- R7: A rejected write raises `viol_o` for exactly the cycle after the request. Allowed writes, reads and idle cycles leave `viol_o` low in the following cycle.
- R8: Unsealed, an allowed write to 0x05 with data bit 6 = 1 sets `sealed_o` from the next cycle. A write to 0x05 with bit 6 = 0 leaves it clear.
- R9: Once sealed, `sealed_o` stays 1 until reset. A write to 0x05 is rejected and does not clear the seal.
- R10: `rf_addr` and `rf_wdata` always follow `req_addr` and `req_wdata`. With `req_valid` low, `rf_we` is 0 and `rsp_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_seal | input | 1 | Seal value loaded while reset is low |
| req_valid | input | 1 | A request is present this cycle |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 7 | Register address of the request |
| req_wdata | input | 8 | Write data of the request |
| rsp_rdata | output | 8 | Read data returned to the interface, zero when masked |
| rf_we | output | 1 | Gated write enable to the register file |
| rf_addr | output | 7 | Address to the register file |
| rf_wdata | output | 8 | Write data to the register file |
| rf_rdata | input | 8 | Read data from the register file |
| viol_o | output | 1 | One-cycle pulse after a rejected write |
| sealed_o | output | 1 | Current seal flag |

## Verification
The bench builds the filter with its default parameters: 7-bit addresses, 8-bit data, the seal at bit 6 of 0x05, and the window bounds listed above. With those values the whole 128-entry map can be swept with both a read and a write in each seal state. Every window edge is covered, including 0x0F/0x10, 0x1F/0x20, 0x76/0x77/0x78, and 0x7A/0x7B/0x7C/0x7D. A second reset with the fuse input set reaches the sealed state without any write.

// File: rtl/acc_filter_pkg.sv
package acc_filter_pkg;

    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_SEALED = 1'b1
    } seal_state_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } perm_t;

endpackage

// File: rtl/window_match.sv
module window_match #(
    parameter int AW = 7,
    parameter int LO = 0,
    parameter int HI = 15
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int TOP = (1 << AW) - 1;

    generate
        if (LO == 0 && HI == TOP) begin : g_all
            assign hit = 1'b1;
        end else if (LO == 0) begin : g_upper_only
            assign hit = (addr <= AW'(HI));
        end else if (HI == TOP) begin : g_lower_only
            assign hit = (addr >= AW'(LO));
        end else if (LO == HI) begin : g_single
            assign hit = (addr == AW'(LO));
        end else begin : g_both
            assign hit = (addr >= AW'(LO)) && (addr <= AW'(HI));
        end
    endgenerate

endmodule

// File: rtl/perm_decode.sv
module perm_decode
    import acc_filter_pkg::*;
#(
    parameter int AW          = 7,
    parameter int OPEN_RW0_LO = 'h00,
    parameter int OPEN_RW0_HI = 'h0F,
    parameter int OPEN_RW1_LO = 'h78,
    parameter int OPEN_RW1_HI = 'h7F,
    parameter int OPEN_RO_LO  = 'h10,
    parameter int OPEN_RO_HI  = 'h1F,
    parameter int STAT_ADDR   = 'h77,
    parameter int SEAL_RD_LO  = 'h77,
    parameter int SEAL_RD_HI  = 'h7F,
    parameter int SEAL_WR_LO  = 'h7B,
    parameter int SEAL_WR_HI  = 'h7C
) (
    input  logic [AW-1:0] addr,
    input  logic          sealed,
    output perm_t         perm
);
    logic hit_rw0, hit_rw1, hit_ro, hit_stat, hit_srd, hit_swr;

    window_match #(.AW(AW), .LO(OPEN_RW0_LO), .HI(OPEN_RW0_HI))
        u_rw0 (.addr(addr), .hit(hit_rw0));
    window_match #(.AW(AW), .LO(OPEN_RW1_LO), .HI(OPEN_RW1_HI))
        u_rw1 (.addr(addr), .hit(hit_rw1));
    window_match #(.AW(AW), .LO(OPEN_RO_LO), .HI(OPEN_RO_HI))
        u_ro (.addr(addr), .hit(hit_ro));
    window_match #(.AW(AW), .LO(STAT_ADDR), .HI(STAT_ADDR))
        u_stat (.addr(addr), .hit(hit_stat));
    window_match #(.AW(AW), .LO(SEAL_RD_LO), .HI(SEAL_RD_HI))
        u_srd (.addr(addr), .hit(hit_srd));
    window_match #(.AW(AW), .LO(SEAL_WR_LO), .HI(SEAL_WR_HI))
        u_swr (.addr(addr), .hit(hit_swr));

    always_comb begin
        if (sealed) begin
            perm.rd_ok = hit_srd;
            perm.wr_ok = hit_swr;
        end else begin
            perm.rd_ok = hit_rw0 | hit_rw1 | hit_ro | hit_stat;
            perm.wr_ok = hit_rw0 | hit_rw1;
        end
    end

endmodule

// File: rtl/seal_fsm.sv
module seal_fsm
    import acc_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fuse_seal,
    input  logic cfg_wr,
    input  logic cfg_bit,
    output logic sealed
);
    seal_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= fuse_seal ? ST_SEALED : ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (cfg_wr && cfg_bit) begin
                    state_d = ST_SEALED;
                end
            end
            ST_SEALED: begin
                state_d = ST_SEALED;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN:   sealed = 1'b0;
            ST_SEALED: sealed = 1'b1;
            default:   sealed = 1'b0;
        endcase
    end

endmodule

// File: rtl/access_gate.sv
module access_gate
    import acc_filter_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  perm_t         perm,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [DW-1:0] rsp_rdata,
    output logic          viol
);
    logic rd_req, wr_req, wr_reject;

    assign wr_req    = req_valid &  req_we;
    assign rd_req    = req_valid & ~req_we;
    assign rf_we     = wr_req & perm.wr_ok;
    assign wr_reject = wr_req & ~perm.wr_ok;
    assign rsp_rdata = (rd_req && perm.rd_ok) ? rf_rdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else begin
            viol <= wr_reject;
        end
    end

endmodule

// File: rtl/acc_protect_filter.sv
module acc_protect_filter
    import acc_filter_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int CFG_ADDR = 'h05,
    parameter int SEAL_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_seal,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              viol_o,
    output logic              sealed_o
);
    perm_t perm;
    logic  sealed;
    logic  cfg_wr;

    assign rf_addr  = req_addr;
    assign rf_wdata = req_wdata;
    assign cfg_wr   = rf_we && (req_addr == ADDR_W'(CFG_ADDR));
    assign sealed_o = sealed;

    perm_decode #(.AW(ADDR_W)) u_dec (
        .addr   (req_addr),
        .sealed (sealed),
        .perm   (perm)
    );

    access_gate #(.DW(DATA_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .perm      (perm),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rsp_rdata (rsp_rdata),
        .viol      (viol_o)
    );

    seal_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fuse_seal (fuse_seal),
        .cfg_wr    (cfg_wr),
        .cfg_bit   (req_wdata[SEAL_BIT]),
        .sealed    (sealed)
    );

endmodule

// File: rtl/acc_protect_filter_chk.sv
module acc_protect_filter_chk #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int CFG_ADDR = 'h05
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              seal_data_bit,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rf_we,
    input logic              viol_o,
    input logic              sealed_o
);
    // R2
    open_rw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sealed_o && req_valid && req_we && (req_addr <= ADDR_W'('h0F))) |-> rf_we);

    // R4
    open_hole_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sealed_o && req_valid && (req_addr >= ADDR_W'('h20)) && (req_addr <= ADDR_W'('h76)))
        |-> (!rf_we && (rsp_rdata == '0)));

    // R5
    sealed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed_o && rf_we) |-> ((req_addr == ADDR_W'('h7B)) || (req_addr == ADDR_W'('h7C))));

    // R6
    sealed_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed_o && req_valid && !req_we && (req_addr < ADDR_W'('h77))) |-> (rsp_rdata == '0));

    // R7
    viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> ($past(req_valid) && $past(req_we) && !$past(rf_we)));

    // R8
    seal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sealed_o) |-> ($past(rf_we) && $past(req_addr == ADDR_W'(CFG_ADDR)) && $past(seal_data_bit)));

    // R9
    seal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_o |=> sealed_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rf_we && (rsp_rdata == '0)));
endmodule

bind acc_protect_filter acc_protect_filter_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_ADDR (CFG_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .seal_data_bit (req_wdata[SEAL_BIT]),
    .rsp_rdata     (rsp_rdata),
    .rf_we         (rf_we),
    .viol_o        (viol_o),
    .sealed_o      (sealed_o)
);

// File: tb/sim_acc_protect_filter.sv
`timescale 1ns/1ps
module sim_acc_protect_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_seal = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_we = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rsp_rdata;
    logic       rf_we;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;
    logic       viol_o;
    logic       sealed_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit m_sealed = 1'b0;
    bit m_viol   = 1'b0;

    always #5 clk = ~clk;

    // register file stand-in: never returns zero
    assign rf_rdata = {1'b1, rf_addr};

    acc_protect_filter u0 (
        .clk(clk), .rst_n(rst_n), .fuse_seal(fuse_seal),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .viol_o(viol_o), .sealed_o(sealed_o)
    );

    function automatic bit m_rd_ok(bit s, int a);
        if (s) return (a >= 'h77);
        return (a <= 'h1F) || (a >= 'h77);
    endfunction

    function automatic bit m_wr_ok(bit s, int a);
        if (s) return (a == 'h7B) || (a == 'h7C);
        return (a <= 'h0F) || (a >= 'h78);
    endfunction

    function automatic string req_of(bit s, int a, bit wr);
        if (s) return wr ? "R5" : "R6";
        if (m_rd_ok(0, a) && m_wr_ok(0, a)) return "R2";
        if (m_rd_ok(0, a)) return "R3";
        return "R4";
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(bit wr, int a, logic [7:0] d);
        bit exp_we;
        logic [7:0] exp_rd;
        string rq;
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = wr;
        req_addr  = a[6:0];
        req_wdata = d;
        #1;
        rq     = req_of(m_sealed, a, wr);
        exp_we = wr && m_wr_ok(m_sealed, a);
        exp_rd = (!wr && m_rd_ok(m_sealed, a)) ? {1'b1, a[6:0]} : 8'h00;
        chk(rf_we == exp_we, rq, "rf_we", int'(rf_we), int'(exp_we));
        chk(rsp_rdata == exp_rd, rq, "rsp_rdata", int'(rsp_rdata), int'(exp_rd));
        chk((rf_addr == a[6:0]) && (rf_wdata == d), "R10", "rf_addr/rf_wdata",
            int'({rf_addr, rf_wdata}), int'({a[6:0], d}));
        // model update at the edge
        m_viol = wr && !exp_we;
        if (exp_we && a == 'h05 && d[6]) m_sealed = 1'b1;
        @(posedge clk);
        #1;
        chk(viol_o == m_viol, "R7", "viol_o", int'(viol_o), int'(m_viol));
        chk(sealed_o == m_sealed, m_sealed ? "R9" : "R8", "sealed_o",
            int'(sealed_o), int'(m_sealed));
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0;
        req_we    = 1'b1;
        req_addr  = 7'h03;
        #1;
        chk(rf_we == 1'b0, "R10", "idle rf_we", int'(rf_we), 0);
        chk(rsp_rdata == 8'h00, "R10", "idle rsp_rdata", int'(rsp_rdata), 0);
        m_viol = 1'b0;
        @(posedge clk);
        #1;
        chk(viol_o == 1'b0, "R7", "idle viol_o", int'(viol_o), 0);
    endtask

    task automatic do_reset(bit fuse);
        @(negedge clk);
        rst_n     = 1'b0;
        fuse_seal = fuse;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        fuse_seal = 1'b0;
        m_sealed = fuse;
        m_viol   = 1'b0;
        #1;
        chk(sealed_o == fuse, "R1", "sealed_o after reset", int'(sealed_o), int'(fuse));
        chk(viol_o == 1'b0, "R1", "viol_o after reset", int'(viol_o), 0);
    endtask

    initial begin
        // R1: unsealed fuse
        do_reset(1'b0);
        idle_cycle();
        // R2 R3 R4 R7: open sweep, writes keep bit 6 clear (R8 negative)
        for (int a = 0; a < 128; a++) access(1'b0, a, 8'h00);
        for (int a = 0; a < 128; a++) access(1'b1, a, 8'(a) & 8'hBF);
        // back-to-back rejected writes then an allowed one (R7)
        access(1'b1, 'h20, 8'h11);
        access(1'b1, 'h77, 8'h22);
        access(1'b1, 'h0F, 8'h33);
        access(1'b0, 'h05, 8'h00);
        // R8: seal via config write
        access(1'b1, 'h05, 8'h40);
        // R5 R6 R9: sealed sweep
        for (int a = 0; a < 128; a++) access(1'b0, a, 8'h00);
        for (int a = 0; a < 128; a++) access(1'b1, a, 8'h00);
        access(1'b1, 'h05, 8'h00);
        idle_cycle();
        // R1: sealed fuse
        do_reset(1'b1);
        access(1'b1, 'h0F, 8'h01);
        access(1'b1, 'h7C, 8'h02);
        access(1'b0, 'h10, 8'h00);
        access(1'b0, 'h7F, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule